// File: doc/BRIEF.md
# Signature Parameter Range Checker

This block screens the inputs of a signature verification before the arithmetic engine is started. Four big-integer comparisons are streamed through it, one byte per cycle and most significant byte first, always in the same order: public-key X coordinate against the field prime, public-key Y coordinate against the field prime, signature half r against the curve order, and signature half s against the curve order. Each comparison is one frame, marked by a first flag on its opening byte and a last flag on its closing byte.

The operand and its bound may have different byte lengths. The upstream source aligns both at the least significant end and marks each missing high-order byte of the shorter value with a pad flag. The block treats a padded byte as zero, whatever its data lines carry. The coordinate checks require strict less-than. The signature checks also require a nonzero value. A per-check verdict appears one cycle after each frame's last byte. The session result follows either when s passes or at the first failure. In the failure case the result carries the index of the failing check, and the sequence goes back to the X check.

Top module: `sigrange_top`

## Requirements
- R1: After synchronous reset, chk_done, chk_ok, res_valid, res_pass, res_fail_idx, chk_idx and pass_vec are all zero, and the next frame is treated as check 0 (X).
- R2: chk_done pulses high for exactly one cycle, in the cycle after a byte carrying in_valid and in_last is accepted. It is low in every other cycle. chk_idx then gives the check index: 0 = X, 1 = Y, 2 = r, 3 = s.
- R3: Bytes are compared from the most significant end down, and the first unequal byte decides the order. An operand equal to its bound is not smaller, so its check fails.
- R4: A byte whose pad flag (op_pad or bnd_pad) is high counts as zero, whatever the value on its byte lines. This zero-extends the shorter value at the top.
- R5: Checks 0 and 1 (X, Y) pass exactly when operand < bound. A zero operand passes.
- R6: Checks 2 and 3 (r, s) pass exactly when operand < bound and at least one operand byte in the frame is nonzero.
- R7: When a check fails, res_valid is high in the same cycle as chk_done, with res_pass = 0 and res_fail_idx equal to the failing index. The next frame is then check 0.
- R8: When check 3 passes, res_valid is high in the same cycle as chk_done, with res_pass = 1 and res_fail_idx = 0. When checks 0 to 2 pass, no result is produced and the index advances by one.
- R9: Bit i of pass_vec holds the verdict of check i in the current session. All bits clear when the first byte of a check-0 frame is accepted, and only the bit of the closing check is written when a frame ends.
- R10: A frame of a single byte, with first and last set together, is a complete comparison.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A byte pair is present this cycle |
| in_first | input | 1 | Byte pair opens a frame |
| in_last | input | 1 | Byte pair closes a frame |
| op_byte | input | BYTE_W | Operand byte, most significant first |
| op_pad | input | 1 | Operand byte is a zero-extension pad |
| bnd_byte | input | BYTE_W | Bound byte, most significant first |
| bnd_pad | input | 1 | Bound byte is a zero-extension pad |
| chk_done | output | 1 | Per-check verdict strobe |
| chk_idx | output | IDX_W | Index of the check just closed |
| chk_ok | output | 1 | Verdict of the check just closed |
| res_valid | output | 1 | Session result strobe |
| res_pass | output | 1 | All four checks passed |
| res_fail_idx | output | IDX_W | Index of the first failing check |
| pass_vec | output | NUM_CHK | Per-check verdicts of the session |

## Verification
Every output comes from one register stage. chk_done, chk_idx, chk_ok, res_valid, res_pass, res_fail_idx and the written pass_vec bit are therefore due exactly one clock after the edge that accepts a last-flagged byte. The bench drives each byte just after a falling edge and reads the outputs at the falling edge that follows the closing byte, which is one rising edge later. It then inserts one idle cycle and confirms that the strobes have dropped, so that a strobe arriving late, or lasting two cycles, is caught as well as a wrong value.

// File: rtl/sigrange_pkg.sv
package sigrange_pkg;

    // Running magnitude relation of operand against bound
    typedef enum logic [1:0] {
        ORD_EQ = 2'd0,
        ORD_LT = 2'd1,
        ORD_GT = 2'd2
    } ord_e;

    // Running state of one comparison frame
    typedef struct packed {
        ord_e ord;
        logic nz;
    } cmp_state_t;

    // Relation decided by one byte pair taken alone
    function automatic ord_e ord_step(input logic [63:0] a, input logic [63:0] b);
        if (a < b)      return ORD_LT;
        else if (a > b) return ORD_GT;
        else            return ORD_EQ;
    endfunction

    // The earlier (more significant) decision wins once made
    function automatic ord_e ord_merge(input ord_e prev, input ord_e cur);
        return (prev == ORD_EQ) ? cur : prev;
    endfunction

    // Verdict of a closed frame
    function automatic logic chk_verdict(input cmp_state_t st, input logic need_nz);
        return (st.ord == ORD_LT) && (st.nz || !need_nz);
    endfunction

endpackage

// File: rtl/sigrange_lane.sv
module sigrange_lane #(
    parameter int BYTE_W = 8
) (
    input  logic [BYTE_W-1:0] raw_byte,
    input  logic              pad,
    output logic [BYTE_W-1:0] eff_byte
);
    // A padded position stands for a leading zero byte
    always_comb begin
        eff_byte = pad ? '0 : raw_byte;
    end
endmodule

// File: rtl/sigrange_cmp.sv
module sigrange_cmp
    import sigrange_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              valid,
    input  logic              first,
    input  logic [BYTE_W-1:0] a_byte,
    input  logic [BYTE_W-1:0] b_byte,
    output cmp_state_t        fin
);
    cmp_state_t run_q;
    cmp_state_t base;

    always_comb begin
        base = first ? cmp_state_t'{ord: ORD_EQ, nz: 1'b0} : run_q;
        fin.ord = ord_merge(base.ord, ord_step(64'(a_byte), 64'(b_byte)));
        fin.nz  = base.nz | (|a_byte);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= '{ord: ORD_EQ, nz: 1'b0};
        end else if (valid) begin
            run_q <= fin;
        end
    end
endmodule

// File: rtl/sigrange_seq.sv
module sigrange_seq
    import sigrange_pkg::*;
#(
    parameter int                 NUM_CHK = 4,
    parameter logic [NUM_CHK-1:0] NZ_MASK = 4'b1100,
    localparam int                IDX_W   = $clog2(NUM_CHK)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               valid,
    input  logic               first,
    input  logic               last,
    input  cmp_state_t         fin,
    output logic               chk_done,
    output logic [IDX_W-1:0]   chk_idx,
    output logic               chk_ok,
    output logic               res_valid,
    output logic               res_pass,
    output logic [IDX_W-1:0]   res_fail_idx,
    output logic [NUM_CHK-1:0] pass_vec
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_CHK - 1);

    logic [IDX_W-1:0] idx_q;
    logic             end_ev;
    logic             start_ev;
    logic             ok;
    logic             finish;

    always_comb begin
        end_ev   = valid && last;
        start_ev = valid && first && (idx_q == '0);
        ok       = chk_verdict(fin, NZ_MASK[idx_q]);
        finish   = end_ev && (!ok || (idx_q == LAST_IDX));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q        <= '0;
            chk_done     <= 1'b0;
            chk_idx      <= '0;
            chk_ok       <= 1'b0;
            res_valid    <= 1'b0;
            res_pass     <= 1'b0;
            res_fail_idx <= '0;
        end else begin
            chk_done  <= end_ev;
            res_valid <= finish;
            if (end_ev) begin
                chk_idx <= idx_q;
                chk_ok  <= ok;
                if (finish) begin
                    res_pass     <= ok;
                    res_fail_idx <= ok ? '0 : idx_q;
                    idx_q        <= '0;
                end else begin
                    idx_q <= idx_q + 1'b1;
                end
            end
        end
    end

    for (genvar i = 0; i < NUM_CHK; i++) begin : g_pass
        always_ff @(posedge clk) begin
            if (rst) begin
                pass_vec[i] <= 1'b0;
            end else if (end_ev && (idx_q == IDX_W'(i))) begin
                pass_vec[i] <= ok;
            end else if (start_ev) begin
                pass_vec[i] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/sigrange_top.sv
module sigrange_top
    import sigrange_pkg::*;
#(
    parameter int                 BYTE_W  = 8,
    parameter int                 NUM_CHK = 4,
    parameter logic [NUM_CHK-1:0] NZ_MASK = 4'b1100,
    localparam int                IDX_W   = $clog2(NUM_CHK)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic               in_first,
    input  logic               in_last,
    input  logic [BYTE_W-1:0]  op_byte,
    input  logic               op_pad,
    input  logic [BYTE_W-1:0]  bnd_byte,
    input  logic               bnd_pad,
    output logic               chk_done,
    output logic [IDX_W-1:0]   chk_idx,
    output logic               chk_ok,
    output logic               res_valid,
    output logic               res_pass,
    output logic [IDX_W-1:0]   res_fail_idx,
    output logic [NUM_CHK-1:0] pass_vec
);
    localparam int N_LANE = 2;

    logic [N_LANE-1:0][BYTE_W-1:0] raw;
    logic [N_LANE-1:0]             pad;
    logic [N_LANE-1:0][BYTE_W-1:0] eff;
    cmp_state_t                    fin;

    always_comb begin
        raw[0] = op_byte;
        raw[1] = bnd_byte;
        pad[0] = op_pad;
        pad[1] = bnd_pad;
    end

    for (genvar l = 0; l < N_LANE; l++) begin : g_lane
        sigrange_lane #(.BYTE_W(BYTE_W)) i_lane (
            .raw_byte (raw[l]),
            .pad      (pad[l]),
            .eff_byte (eff[l])
        );
    end

    sigrange_cmp #(.BYTE_W(BYTE_W)) i_cmp (
        .clk    (clk),
        .rst    (rst),
        .valid  (in_valid),
        .first  (in_first),
        .a_byte (eff[0]),
        .b_byte (eff[1]),
        .fin    (fin)
    );

    sigrange_seq #(.NUM_CHK(NUM_CHK), .NZ_MASK(NZ_MASK)) i_seq (
        .clk          (clk),
        .rst          (rst),
        .valid        (in_valid),
        .first        (in_first),
        .last         (in_last),
        .fin          (fin),
        .chk_done     (chk_done),
        .chk_idx      (chk_idx),
        .chk_ok       (chk_ok),
        .res_valid    (res_valid),
        .res_pass     (res_pass),
        .res_fail_idx (res_fail_idx),
        .pass_vec     (pass_vec)
    );
endmodule

// File: rtl/sigrange_checker.sv
module sigrange_checker #(
    parameter int NUM_CHK = 4,
    parameter int IDX_W   = 2
) (
    input logic               clk,
    input logic               rst,
    input logic               in_valid,
    input logic               in_last,
    input logic               chk_done,
    input logic [IDX_W-1:0]   chk_idx,
    input logic               chk_ok,
    input logic               res_valid,
    input logic               res_pass,
    input logic [IDX_W-1:0]   res_fail_idx,
    input logic [NUM_CHK-1:0] pass_vec
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_CHK - 1);

    assert_done_after_last_R2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_last) |=> chk_done);

    assert_no_stray_done_R2: assert property (@(posedge clk) disable iff (rst)
        !(in_valid && in_last) |=> !chk_done);

    assert_result_with_done_R7: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> chk_done);

    assert_fail_reports_R7: assert property (@(posedge clk) disable iff (rst)
        (chk_done && !chk_ok) |-> (res_valid && !res_pass && (res_fail_idx == chk_idx)));

    assert_pass_only_at_end_R8: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_pass) |-> (chk_ok && (chk_idx == LAST_IDX) && (res_fail_idx == '0)));

    assert_no_early_result_R8: assert property (@(posedge clk) disable iff (rst)
        (chk_done && chk_ok && (chk_idx != LAST_IDX)) |-> !res_valid);

    assert_verdict_bit_R9: assert property (@(posedge clk) disable iff (rst)
        chk_done |-> (pass_vec[chk_idx] == chk_ok));
endmodule

bind sigrange_top sigrange_checker #(.NUM_CHK(NUM_CHK), .IDX_W(IDX_W)) i_sigrange_checker (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .in_last      (in_last),
    .chk_done     (chk_done),
    .chk_idx      (chk_idx),
    .chk_ok       (chk_ok),
    .res_valid    (res_valid),
    .res_pass     (res_pass),
    .res_fail_idx (res_fail_idx),
    .pass_vec     (pass_vec)
);

// File: tb/test_sigrange_top.sv
module test_sigrange_top;
    localparam int BYTE_W  = 8;
    localparam int NUM_CHK = 4;
    localparam int IDX_W   = 2;

    logic               clk = 1'b0;
    logic               rst;
    logic               in_valid, in_first, in_last, op_pad, bnd_pad;
    logic [BYTE_W-1:0]  op_byte, bnd_byte;
    logic               chk_done, chk_ok, res_valid, res_pass;
    logic [IDX_W-1:0]   chk_idx, res_fail_idx;
    logic [NUM_CHK-1:0] pass_vec;

    int n_vec = 0;
    int n_err = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    sigrange_top i_sigrange_top (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_first(in_first),
        .in_last(in_last), .op_byte(op_byte), .op_pad(op_pad),
        .bnd_byte(bnd_byte), .bnd_pad(bnd_pad), .chk_done(chk_done),
        .chk_idx(chk_idx), .chk_ok(chk_ok), .res_valid(res_valid),
        .res_pass(res_pass), .res_fail_idx(res_fail_idx), .pass_vec(pass_vec)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic bit exp_ok(input int idx, input logic [63:0] ov, input logic [63:0] bv);
        if (idx >= 2) return (ov < bv) && (ov != 0);
        return ov < bv;
    endfunction

    task automatic idle();
        in_valid = 0; in_first = 0; in_last = 0;
        op_pad = 0; bnd_pad = 0;
        op_byte = $urandom; bnd_byte = $urandom;
    endtask

    // Stream one frame; the operand occupies ol bytes, the bound bl bytes
    task automatic run_frame(input logic [63:0] ov, input int ol,
                             input logic [63:0] bv, input int bl);
        int len = (ol > bl) ? ol : bl;
        for (int k = 0; k < len; k++) begin
            int sh = 8 * (len - 1 - k);
            in_valid = 1;
            in_first = (k == 0);
            in_last  = (k == len - 1);
            op_pad   = (k < len - ol);
            bnd_pad  = (k < len - bl);
            op_byte  = op_pad  ? 8'($urandom) : 8'(ov >> sh);
            bnd_byte = bnd_pad ? 8'($urandom) : 8'(bv >> sh);
            @(negedge clk);
        end
        idle();
    endtask

    // Runs checks from 0 until the first failure; verifies every output
    task automatic run_session(input logic [63:0] ov[4], input int ol[4],
                               input logic [63:0] bv[4], input int bl[4]);
        logic [3:0] pv = 4'b0;
        for (int i = 0; i < 4; i++) begin
            bit ok = exp_ok(i, ov[i], bv[i]);
            bit fin = !ok || (i == 3);
            run_frame(ov[i], ol[i], bv[i], bl[i]);
            pv[i] = ok;
            check("R2 chk_done", 32'(chk_done), 1);
            check("R2 chk_idx", 32'(chk_idx), 32'(i));
            check(i >= 2 ? "R6 r/s verdict" : "R5 X/Y verdict", 32'(chk_ok), 32'(ok));
            check("R9 pass_vec", 32'(pass_vec), 32'(pv));
            check(ok ? "R8 res_valid" : "R7 res_valid", 32'(res_valid), 32'(fin));
            if (fin) begin
                check(ok ? "R8 res_pass" : "R7 res_pass", 32'(res_pass), 32'(ok));
                check(ok ? "R8 fail_idx" : "R7 fail_idx", 32'(res_fail_idx), ok ? 0 : 32'(i));
            end
            @(negedge clk);
            check("R2 single pulse", 32'(chk_done), 0);
            if (fin) break;
        end
    endtask

    task automatic one_check(input string req, input int idx, input logic [63:0] ov, input int ol,
                             input logic [63:0] bv, input int bl, input bit exp);
        // advance to the requested index with passing checks
        for (int i = 0; i < idx; i++) begin
            run_frame(1, 1, 2, 1);
            @(negedge clk);
        end
        run_frame(ov, ol, bv, bl);
        check(req, 32'(chk_ok), 32'(exp));
        check(req, 32'(chk_idx), 32'(idx));
        @(negedge clk);
        // return to check 0
        if (exp) begin
            for (int i = idx + 1; i < 4; i++) begin
                run_frame(0, 1, 0, 1);
                @(negedge clk);
                if (i >= 0) break;
            end
        end
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        idle();
        rst = 1;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 chk_done", 32'(chk_done), 0);
        check("R1 chk_ok", 32'(chk_ok), 0);
        check("R1 res_valid", 32'(res_valid), 0);
        check("R1 res_pass", 32'(res_pass), 0);
        check("R1 fail_idx", 32'(res_fail_idx), 0);
        check("R1 chk_idx", 32'(chk_idx), 0);
        check("R1 pass_vec", 32'(pass_vec), 0);
        rst = 0;
        @(negedge clk);

        // R1: first frame after reset is check 0; R5 zero X passes
        run_frame(0, 1, 8'h05, 1);
        check("R1 first index", 32'(chk_idx), 0);
        check("R5 zero X passes", 32'(chk_ok), 1);
        @(negedge clk);
        // Y equal -> fails (R3), session ends at index 1
        run_frame(64'h1234, 2, 64'h1234, 2);
        check("R3 equal fails", 32'(chk_ok), 0);
        check("R7 fail idx 1", 32'(res_fail_idx), 1);
        check("R7 res_pass", 32'(res_pass), 0);
        check("R9 pass_vec", 32'(pass_vec), 32'b0001);
        @(negedge clk);
        // R7: next frame is check 0 again
        run_frame(1, 1, 2, 1);
        check("R7 back to 0", 32'(chk_idx), 0);
        check("R9 cleared", 32'(pass_vec), 32'b0001);
        @(negedge clk);
        // R3: first unequal byte decides (0x01FF < 0x0200)
        run_frame(64'h01FF, 2, 64'h0200, 2);
        check("R3 msb decides", 32'(chk_ok), 1);
        @(negedge clk);
        // R10 single byte r = 0 fails on nonzero rule (R6)
        run_frame(0, 1, 8'h80, 1);
        check("R6 zero r fails", 32'(chk_ok), 0);
        check("R7 fail idx 2", 32'(res_fail_idx), 2);
        check("R10 single byte", 32'(chk_done), 1);
        check("R9 pass_vec", 32'(pass_vec), 32'b0011);
        @(negedge clk);

        // R4: longer operand with leading zeros vs short bound; pads carry garbage
        begin
            logic [63:0] ov[4] = '{64'h00_0000_1234, 64'h00_00FF_FFFE, 64'h0000_0001, 64'h7F};
            int          ol[4] = '{5, 5, 4, 1};
            logic [63:0] bv[4] = '{64'h1235, 64'hFF_FFFF, 64'h02, 64'h0180};
            int          bl[4] = '{2, 3, 1, 2};
            run_session(ov, ol, bv, bl);
            check("R8 all pass", 32'(res_pass), 1);
            check("R4 pass_vec", 32'(pass_vec), 32'hF);
        end
        // R4: padded bound is smaller than a long operand
        begin
            logic [63:0] ov[4] = '{64'h01_0000, 64'h0, 64'h0, 64'h0};
            int          ol[4] = '{3, 1, 1, 1};
            logic [63:0] bv[4] = '{64'hFFFF, 64'h1, 64'h1, 64'h1};
            int          bl[4] = '{2, 1, 1, 1};
            run_session(ov, ol, bv, bl);
            check("R4 pad zero in bound", 32'(res_fail_idx), 0);
        end
        // s equal to n fails at index 3
        begin
            logic [63:0] ov[4] = '{64'h10, 64'h10, 64'h10, 64'hABCD};
            int          ol[4] = '{1, 1, 1, 2};
            logic [63:0] bv[4] = '{64'h11, 64'h11, 64'h11, 64'hABCD};
            int          bl[4] = '{1, 1, 1, 2};
            run_session(ov, ol, bv, bl);
            check("R7 fail idx 3", 32'(res_fail_idx), 3);
        end

        // Random sessions
        for (int s = 0; s < 300; s++) begin
            logic [63:0] ov[4];
            int          ol[4];
            logic [63:0] bv[4];
            int          bl[4];
            for (int i = 0; i < 4; i++) begin
                int need;
                logic [63:0] msk;
                bl[i] = 1 + ($urandom % 6);
                msk = (64'h1 << (8 * bl[i])) - 1;
                bv[i] = {$urandom, $urandom} & msk;
                case ($urandom % 6)
                    0: ov[i] = bv[i];
                    1: ov[i] = (bv[i] == 0) ? 0 : bv[i] - 1;
                    2: ov[i] = (bv[i] + 1) & msk;
                    3: ov[i] = 0;
                    default: ov[i] = {$urandom, $urandom} & ((64'h1 << (8 * (1 + ($urandom % 6)))) - 1);
                endcase
                if ($urandom % 4 != 0) ov[i] = (bv[i] == 0) ? 0 : ov[i] % (bv[i] + 1);
                need = 1;
                for (int b = 1; b < 8; b++) if ((ov[i] >> (8 * b)) != 0) need = b + 1;
                ol[i] = need + ($urandom % 3);
            end
            run_session(ov, ol, bv, bl);
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_vec++;
            n_err++;
            $display("FAIL watchdog: run did not complete");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
            $finish;
        end
    end
endmodule